// File: doc/BRIEF.md
# I2C Bus-Segment Connection Controller

This block decides when two I2C bus segments, an input side and an output side, may be joined after power-up or hot insertion. It receives a supply-good flag, accelerator configuration, a recovery-in-progress flag and the sampled SDA/SCL levels of both segments. Each side has its own monitor that synchronizes the lines, detects STOP conditions and measures bus-idle time.

The block stays in lockout while the supply is not good. Once the supply is good, it waits until both segments are quiet, or until one segment has just finished with a STOP and the other is idle. Only then does it join the segments. From that point on it drives open-drain pull-down enables so that each line behaves as a single wired-AND across both segments.

The block also produces four rise-time accelerator enables. These are gated by the connection state, by a disable-all input, by an output-side-only mode and by the recovery flag.

Top module: `i2c_seg_link`

## Requirements
- R1: While `supply_ok_i` is low, the block ignores all line activity. From the cycle after `supply_ok_i` is seen low, `linked_o`, all four pull-down enables and `acc_en_o` are 0.
- R2: The segments are never joined while either segment is in the middle of a transaction, meaning a line has been low within the last `IDLE_CYCLES` cycles and no STOP has followed.
- R3: A side is idle once its synchronized SDA and SCL have both been high for `IDLE_CYCLES` consecutive cycles. A STOP is a synchronized SDA rising edge while SCL is high. The block joins the segments when both sides are idle, or when one side shows a STOP while the other side is idle.
- R4: While joined, a low driven externally on one segment's SDA (or SCL) causes the block to pull the same line low on the other segment. The block never pulls the same line low on both segments at once.
- R5: While joined, each line reads high on both segments once every external driver on both segments has released it. The block does not latch a line low after the external drivers release it.
- R6: `acc_en_o` is 0 until the segments are joined.
- R7: `acc_en_o` bit order is [0] input SDA, [1] input SCL, [2] output SDA, [3] output SCL. When `acc_off_i` is 1, all four bits are 0. When `acc_out_only_i` is 1, bits [1:0] are 0. When joined with neither of these inputs set, all four bits are 1.
- R8: While `recov_active_i` is 1, `acc_en_o` is 0.
- R9: A drop of `supply_ok_i` disconnects the segments. Rejoining afterwards requires the STOP/idle rule to be met again on fresh observations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply good; low forces lockout |
| acc_off_i | input | 1 | Disables all four accelerators |
| acc_out_only_i | input | 1 | Limits accelerators to the output segment |
| recov_active_i | input | 1 | Stuck-bus recovery sequence in progress |
| in_sda_i | input | 1 | Sampled input-segment SDA level |
| in_scl_i | input | 1 | Sampled input-segment SCL level |
| out_sda_i | input | 1 | Sampled output-segment SDA level |
| out_scl_i | input | 1 | Sampled output-segment SCL level |
| in_sda_pd_o | output | 1 | Pull-down enable, input SDA |
| in_scl_pd_o | output | 1 | Pull-down enable, input SCL |
| out_sda_pd_o | output | 1 | Pull-down enable, output SDA |
| out_scl_pd_o | output | 1 | Pull-down enable, output SCL |
| linked_o | output | 1 | Segments joined |
| acc_en_o | output | 4 | Accelerator enables, order per R7 |

## Verification
The assertions assume that each line input reflects the wired-AND of the external drivers and the block's own pull-down, with no more than a register of delay. They also assume that `supply_ok_i` and the configuration inputs are synchronous to `clk_i`. The stimulus models every pin as exactly that wired-AND and changes SDA only while SCL is low, except at START and STOP. It holds each line level for longer than the synchronizer depth, so every edge the block sees is a real bus event.

// File: rtl/seg_link_pkg.sv
package seg_link_pkg;
  typedef enum logic [1:0] {
    LK_LOCKOUT = 2'd0,
    LK_WATCH   = 2'd1,
    LK_JOINED  = 2'd2
  } link_state_e;

  // ownership of one forwarded line
  typedef enum logic [2:0] {
    OWN_NONE   = 3'd0,
    OWN_A      = 3'd1,
    OWN_B      = 3'd2,
    OWN_HOLD_A = 3'd3,
    OWN_HOLD_B = 3'd4
  } own_state_e;

  localparam int SIDE_IN  = 0;
  localparam int SIDE_OUT = 1;
  localparam int NUM_SIDES = 2;
  localparam int NUM_LINES = 2;
endpackage

// File: rtl/seg_monitor.sv
module seg_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_s_o,
  output logic scl_s_o,
  output logic stop_o,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYCLES);

  logic [SYNC_STAGES-1:0] sda_q, scl_q;
  logic sda_d_q;
  logic [CW-1:0] cnt_q;

  assign sda_s_o = sda_q[SYNC_STAGES-1];
  assign scl_s_o = scl_q[SYNC_STAGES-1];

  // synchronizers preset to released so lockout exit never fakes an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q   <= '1;
      scl_q   <= '1;
      sda_d_q <= 1'b1;
    end else if (clear_i) begin
      sda_q   <= '1;
      scl_q   <= '1;
      sda_d_q <= 1'b1;
    end else begin
      sda_q   <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_q   <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_d_q <= sda_s_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (sda_s_o && scl_s_o) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign stop_o = sda_s_o & ~sda_d_q & scl_s_o;
  assign idle_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/link_ctrl.sv
module link_ctrl
  import seg_link_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 supply_ok_i,
  input  logic [NUM_SIDES-1:0] idle_i,
  input  logic [NUM_SIDES-1:0] stop_i,
  output logic                 clear_o,
  output logic                 joined_o
);
  link_state_e state_q, state_d;
  logic join_ok;

  assign join_ok = (idle_i[SIDE_IN] & idle_i[SIDE_OUT])
                 | (stop_i[SIDE_IN] & idle_i[SIDE_OUT])
                 | (stop_i[SIDE_OUT] & idle_i[SIDE_IN]);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_LOCKOUT: if (supply_ok_i) state_d = LK_WATCH;
      LK_WATCH:   if (join_ok) state_d = LK_JOINED;
      LK_JOINED:  state_d = LK_JOINED;
      default:    state_d = LK_LOCKOUT;
    endcase
    if (!supply_ok_i) state_d = LK_LOCKOUT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_LOCKOUT;
    else         state_q <= state_d;
  end

  assign clear_o  = (state_q == LK_LOCKOUT);
  assign joined_o = (state_q == LK_JOINED);
endmodule

// File: rtl/line_forward.sv
module line_forward
  import seg_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic a_low_i,
  input  logic b_low_i,
  output logic pd_a_o,
  output logic pd_b_o
);
  localparam int HW = $clog2(SYNC_STAGES + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(SYNC_STAGES);

  own_state_e st_q, st_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    unique case (st_q)
      OWN_NONE: begin
        if (a_low_i)      st_d = OWN_A;
        else if (b_low_i) st_d = OWN_B;
      end
      OWN_A: if (!a_low_i) begin
        st_d   = OWN_HOLD_A;
        hold_d = HOLD_LOAD;
      end
      OWN_B: if (!b_low_i) begin
        st_d   = OWN_HOLD_B;
        hold_d = HOLD_LOAD;
      end
      // the side just released still shows a stale low; only the owner may reclaim
      OWN_HOLD_A: begin
        if (a_low_i)          st_d = OWN_A;
        else if (hold_q == 0) st_d = OWN_NONE;
        else                  hold_d = hold_q - 1'b1;
      end
      OWN_HOLD_B: begin
        if (b_low_i)          st_d = OWN_B;
        else if (hold_q == 0) st_d = OWN_NONE;
        else                  hold_d = hold_q - 1'b1;
      end
      default: st_d = OWN_NONE;
    endcase
    if (!en_i) begin
      st_d   = OWN_NONE;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= OWN_NONE;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign pd_a_o = (st_q == OWN_B);
  assign pd_b_o = (st_q == OWN_A);
endmodule

// File: rtl/accel_gate.sv
module accel_gate (
  input  logic       joined_i,
  input  logic       acc_off_i,
  input  logic       acc_out_only_i,
  input  logic       recov_active_i,
  output logic [3:0] acc_en_o
);
  logic live;
  assign live = joined_i & ~acc_off_i & ~recov_active_i;
  assign acc_en_o = live ? (acc_out_only_i ? 4'b1100 : 4'b1111) : 4'b0000;
endmodule

// File: rtl/i2c_seg_link.sv
module i2c_seg_link
  import seg_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       acc_off_i,
  input  logic       acc_out_only_i,
  input  logic       recov_active_i,
  input  logic       in_sda_i,
  input  logic       in_scl_i,
  input  logic       out_sda_i,
  input  logic       out_scl_i,
  output logic       in_sda_pd_o,
  output logic       in_scl_pd_o,
  output logic       out_sda_pd_o,
  output logic       out_scl_pd_o,
  output logic       linked_o,
  output logic [3:0] acc_en_o
);
  logic [NUM_SIDES-1:0] sda_raw, scl_raw, sda_s, scl_s, idle_s, stop_s;
  logic clear_mon, joined;
  logic [NUM_LINES-1:0] pd_in, pd_out;

  assign sda_raw = {out_sda_i, in_sda_i};
  assign scl_raw = {out_scl_i, in_scl_i};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    seg_monitor #(
      .SYNC_STAGES (SYNC_STAGES),
      .IDLE_CYCLES (IDLE_CYCLES)
    ) u_mon (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_mon),
      .sda_i   (sda_raw[s]),
      .scl_i   (scl_raw[s]),
      .sda_s_o (sda_s[s]),
      .scl_s_o (scl_s[s]),
      .stop_o  (stop_s[s]),
      .idle_o  (idle_s[s])
    );
  end

  link_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .idle_i      (idle_s),
    .stop_i      (stop_s),
    .clear_o     (clear_mon),
    .joined_o    (joined)
  );

  // line 0 = SDA, line 1 = SCL
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic a_low, b_low;
    assign a_low = (l == 0) ? ~sda_s[SIDE_IN]  : ~scl_s[SIDE_IN];
    assign b_low = (l == 0) ? ~sda_s[SIDE_OUT] : ~scl_s[SIDE_OUT];
    line_forward #(.SYNC_STAGES(SYNC_STAGES)) u_fwd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (joined & supply_ok_i),
      .a_low_i (a_low),
      .b_low_i (b_low),
      .pd_a_o  (pd_in[l]),
      .pd_b_o  (pd_out[l])
    );
  end

  accel_gate u_acc (
    .joined_i       (joined),
    .acc_off_i      (acc_off_i),
    .acc_out_only_i (acc_out_only_i),
    .recov_active_i (recov_active_i),
    .acc_en_o       (acc_en_o)
  );

  assign in_sda_pd_o  = pd_in[0];
  assign in_scl_pd_o  = pd_in[1];
  assign out_sda_pd_o = pd_out[0];
  assign out_scl_pd_o = pd_out[1];
  assign linked_o     = joined;
endmodule

// File: rtl/seg_link_chk.sv
module seg_link_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       acc_off_i,
  input logic       acc_out_only_i,
  input logic       recov_active_i,
  input logic       linked_o,
  input logic [3:0] acc_en_o,
  input logic [3:0] pd_i,
  input logic [1:0] idle_i,
  input logic [1:0] stop_i
);
  // R1
  lockout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!linked_o && pd_i == 4'b0 && acc_en_o == 4'b0));

  // R3
  join_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(linked_o) |-> $past((idle_i[0] & idle_i[1]) | (stop_i[0] & idle_i[1]) | (stop_i[1] & idle_i[0])));

  // R4
  sda_one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_i[3] && pd_i[1]));

  // R4
  scl_one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_i[2] && pd_i[0]));

  // R6
  acc_needs_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_o != 4'b0) |-> linked_o);

  // R7
  acc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_off_i |-> acc_en_o == 4'b0);

  // R7
  acc_out_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_out_only_i |-> acc_en_o[1:0] == 2'b00);

  // R8
  acc_recov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_active_i |-> acc_en_o == 4'b0);

  // R9
  pd_needs_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_i != 4'b0) |-> linked_o);
endmodule

bind i2c_seg_link seg_link_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .supply_ok_i    (supply_ok_i),
  .acc_off_i      (acc_off_i),
  .acc_out_only_i (acc_out_only_i),
  .recov_active_i (recov_active_i),
  .linked_o       (linked_o),
  .acc_en_o       (acc_en_o),
  .pd_i           ({in_sda_pd_o, in_scl_pd_o, out_sda_pd_o, out_scl_pd_o}),
  .idle_i         (idle_s),
  .stop_i         (stop_s)
);

// File: tb/sim_i2c_seg_link.sv
`timescale 1ns/100ps
module sim_i2c_seg_link;
  localparam int IDLE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, acc_off = 1'b0, acc_out_only = 1'b0, recov = 1'b0;
  logic e_in_sda = 1'b1, e_in_scl = 1'b1, e_out_sda = 1'b1, e_out_scl = 1'b1;
  logic in_sda, in_scl, out_sda, out_scl;
  logic in_sda_pd, in_scl_pd, out_sda_pd, out_scl_pd, linked;
  logic [3:0] acc_en;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign in_sda  = e_in_sda  & ~in_sda_pd;
  assign in_scl  = e_in_scl  & ~in_scl_pd;
  assign out_sda = e_out_sda & ~out_sda_pd;
  assign out_scl = e_out_scl & ~out_scl_pd;

  i2c_seg_link #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok),
    .acc_off_i(acc_off), .acc_out_only_i(acc_out_only), .recov_active_i(recov),
    .in_sda_i(in_sda), .in_scl_i(in_scl), .out_sda_i(out_sda), .out_scl_i(out_scl),
    .in_sda_pd_o(in_sda_pd), .in_scl_pd_o(in_scl_pd),
    .out_sda_pd_o(out_sda_pd), .out_scl_pd_o(out_scl_pd),
    .linked_o(linked), .acc_en_o(acc_en));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet_check(string req);
    check(!linked, req, int'(linked), 0);
    check({in_sda_pd, in_scl_pd, out_sda_pd, out_scl_pd} == 4'b0, req,
          int'({in_sda_pd, in_scl_pd, out_sda_pd, out_scl_pd}), 0);
    check(acc_en == 4'b0, req, int'(acc_en), 0);
  endtask

  // input-side traffic; SDA moves only while SCL low
  task automatic in_start();
    e_in_sda = 1'b0; tick(3); e_in_scl = 1'b0; tick(2);
  endtask
  task automatic in_bits(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      e_in_sda = v[i]; tick(2); e_in_scl = 1'b1; tick(3); e_in_scl = 1'b0; tick(2);
    end
  endtask
  task automatic in_stop();
    e_in_sda = 1'b0; tick(2); e_in_scl = 1'b1; tick(3); e_in_sda = 1'b1;
  endtask

  initial begin
    tick(3);
    // reset state
    quiet_check("R1");
    rst_n = 1'b1;
    tick(2);
    // lockout: traffic and long idle are ignored
    in_start(); in_bits(8'hA5); in_stop();
    tick(IDLE + 20);
    quiet_check("R1");

    // supply up with input segment busy
    supply_ok = 1'b1;
    in_start(); in_bits(8'h3C);
    check(!linked, "R2", int'(linked), 0);
    in_bits(8'hC3);
    check(!linked, "R2", int'(linked), 0);
    check(acc_en == 4'b0, "R6", int'(acc_en), 0);
    in_stop();
    tick(6); // STOP + idle opposite side -> join well before IDLE
    check(linked, "R3", int'(linked), 1);
    check(acc_en == 4'hF, "R7", int'(acc_en), 'hF);

    // wired-AND sweep over all external driver combinations
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cv;
      cv = 4'(c);
      {e_in_sda, e_in_scl, e_out_sda, e_out_scl} = cv;
      tick(14);
      check(in_sda == (cv[3] & cv[1]) && out_sda == (cv[3] & cv[1]), "R4",
            int'({in_sda, out_sda}), int'({2{cv[3] & cv[1]}}));
      check(in_scl == (cv[2] & cv[0]) && out_scl == (cv[2] & cv[0]), "R5",
            int'({in_scl, out_scl}), int'({2{cv[2] & cv[0]}}));
    end
    check({in_sda, in_scl, out_sda, out_scl} == 4'hF, "R5",
          int'({in_sda, in_scl, out_sda, out_scl}), 'hF);

    // accelerator configuration sweep
    for (int c = 0; c < 8; c++) begin
      logic [3:0] exp_acc;
      {acc_off, acc_out_only, recov} = 3'(c);
      #1;
      exp_acc = (acc_off | recov) ? 4'b0000 : (acc_out_only ? 4'b1100 : 4'b1111);
      check(acc_en == exp_acc, recov ? "R8" : "R7", int'(acc_en), int'(exp_acc));
      tick(1);
    end
    {acc_off, acc_out_only, recov} = 3'b000;

    // supply drop while forwarding a low
    e_in_sda = 1'b0;
    tick(10);
    check(!out_sda, "R4", int'(out_sda), 0);
    supply_ok = 1'b0;
    tick(1);
    quiet_check("R9");
    check(out_sda, "R9", int'(out_sda), 1);
    e_in_sda = 1'b1;
    tick(3);

    // re-up: output segment held busy, input STOP must not join
    e_out_scl = 1'b0;
    supply_ok = 1'b1;
    tick(2);
    in_start(); in_bits(8'h81); in_stop();
    tick(10);
    check(!linked, "R3", int'(linked), 0);
    e_out_scl = 1'b1;
    tick(10);
    check(!linked, "R9", int'(linked), 0);
    tick(IDLE + 6);
    check(linked, "R3", int'(linked), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule